// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Master

This block loads a bitstream into a target FPGA over a passive-serial link. A session starts when `start_i` is seen while the block is idle. The block first drives the active-low configuration request low for a fixed time. It then accepts bytes from a valid/ready stream and shifts each one onto a single data line, together with a configuration clock that it generates. The target captures each bit on the rising edge of that clock.

The host marks the final byte with `last_i`. After that byte has been shifted out, the block holds the clock low for a settling interval. It then samples the target's done input and reports pass or fail with a one-cycle strobe. The target's status input is registered and always visible. If the status input falls while bytes are streaming, the session is aborted and an error flag is set.

The request pulse and the settling interval are given in nanoseconds and are converted to system clocks from the clock frequency parameter, rounding up. The low and high phases of the configuration clock are counted directly in system clocks.

Top module: `ps_cfg_master`

## Requirements
- R1: A `start_i` seen while idle drives `cfg_n_o` low for exactly ceil(SYS_CLK_HZ·PULSE_NS/1e9) cycles, which is 625 cycles at the defaults. `cfg_n_o` then returns high.
- R2: Each accepted byte is sent as exactly 8 bits, least significant bit first, in the order the bytes were accepted.
- R3: Every bit takes 1 + LOW_CYC + HIGH_CYC cycles:
  - the clock is low for one cycle with the previous data;
  - it stays low for LOW_CYC cycles with the new bit;
  - it is high for HIGH_CYC cycles.
  `data_o` never changes unless `dclk_o` is low in both that cycle and the one before.
- R4: `ready_o` is high only while streaming, with the status flag high and the final byte not yet taken. It also needs one of two conditions: no byte is held, or the last high cycle of bit 7 is in progress. A byte accepted in that last cycle starts on the next cycle, with no gap.
- R5: After the last bit of the final byte, the clock stays low for ceil(SYS_CLK_HZ·SETTLE_NS/1e9) cycles, which is 1250 at the defaults. `done_i` is then sampled. `result_valid_o` pulses for one cycle, and `pass_o` holds the sampled level until the next session starts.
- R6: `status_o` equals `status_i` delayed by one clock.
- R7: If `status_o` is low while streaming, the next edge ends the session. At that edge `dclk_o` goes low, `busy_o` falls and `err_o` is set, and no result strobe is given.
- R8: Outside a session `cfg_n_o` is high and `dclk_o` is low. `data_o` is low from the second idle cycle onward.
- R9: `busy_o` rises on the edge that starts the request pulse. It falls on the edge that raises the result strobe, or on the abort edge.
- R10: `start_i` has no effect while `busy_o` is high.
- R11: A new session clears `err_o` and `pass_o` on its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration session |
| byte_i | input | 8 | Stream byte |
| valid_i | input | 1 | Stream byte valid |
| last_i | input | 1 | Marks the final byte of the stream |
| ready_o | output | 1 | Block accepts the stream byte |
| status_i | input | 1 | Target status level |
| done_i | input | 1 | Target done level |
| cfg_n_o | output | 1 | Configuration request, active low |
| dclk_o | output | 1 | Configuration clock |
| data_o | output | 1 | Serial data |
| status_o | output | 1 | Registered status flag |
| busy_o | output | 1 | Session in progress |
| result_valid_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Sampled done level from the last session |
| err_o | output | 1 | Session aborted by a status drop |

## Verification
Two events can fall in the same cycle:
- the end of the last high phase of a byte's eighth bit, where the clock falls;
- the acceptance of the next byte.

The bench provokes this by holding `valid_i` high for whole sessions, so each new byte is taken in the closing cycle of the previous one. A behavioural model built from bit queues is compared with every output on every clock. Any lost or extra cycle at that boundary therefore shows up as a mismatch in `ready_o`, `dclk_o` or `data_o`. The recovered bytes must also equal the bytes that were sent. A second case drops the status input while bytes stream, which aborts the session part way through a bit.

// File: rtl/psc_pkg.sv
package psc_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_STREAM, ST_SETTLE} seq_state_e;
  typedef enum logic [1:0] {PH_FALL, PH_LOW, PH_HIGH} bit_phase_e;

  // round up, never below one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned hz, input int unsigned ns);
    longint unsigned c;
    c = (64'(hz) * 64'(ns) + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/psc_timer.sv
module psc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i - W'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - W'(1);
    end
  end

  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/psc_shifter.sv
module psc_shifter
  import psc_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 2,
  parameter int unsigned HIGH_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              can_load_o,
  output logic              word_end_o,
  output logic              dclk_o,
  output logic              data_o
);
  localparam int unsigned PH_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int unsigned CW     = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam int unsigned BW     = $clog2(BYTE_W);

  bit_phase_e        ph_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              have_q;
  logic              last_hi;

  assign last_hi    = (ph_q == PH_HIGH) && (cnt_q == CW'(HIGH_CYC - 1));
  assign word_end_o = have_q && last_hi && (bit_q == BW'(BYTE_W - 1));
  assign can_load_o = !have_q || word_end_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_FALL;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      have_q <= 1'b0;
      dclk_o <= 1'b0;
      data_o <= 1'b0;
    end else if (!run_i) begin
      have_q <= 1'b0;
      ph_q   <= PH_FALL;
      cnt_q  <= '0;
      dclk_o <= 1'b0;
      if (!dclk_o) data_o <= 1'b0;  // clear only once clock is already low
    end else if (!have_q) begin
      if (load_i) begin
        sh_q   <= byte_i;
        have_q <= 1'b1;
        ph_q   <= PH_FALL;
        bit_q  <= '0;
        cnt_q  <= '0;
      end
    end else begin
      unique case (ph_q)
        PH_FALL: begin
          data_o <= sh_q[0];
          ph_q   <= PH_LOW;
          cnt_q  <= '0;
        end
        PH_LOW: begin
          if (cnt_q == CW'(LOW_CYC - 1)) begin
            dclk_o <= 1'b1;
            ph_q   <= PH_HIGH;
            cnt_q  <= '0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        PH_HIGH: begin
          if (last_hi) begin
            dclk_o <= 1'b0;
            cnt_q  <= '0;
            ph_q   <= PH_FALL;
            if (bit_q != BW'(BYTE_W - 1)) begin
              bit_q <= bit_q + BW'(1);
              sh_q  <= sh_q >> 1;
            end else if (load_i) begin
              sh_q  <= byte_i;
              bit_q <= '0;
            end else have_q <= 1'b0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: ph_q <= PH_FALL;
      endcase
    end
  end
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import psc_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 125_000_000,
  parameter int unsigned PULSE_NS   = 5000,
  parameter int unsigned SETTLE_NS  = 10000,
  parameter int unsigned LOW_CYC    = 2,
  parameter int unsigned HIGH_CYC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  input  logic              status_i,
  input  logic              done_i,
  output logic              cfg_n_o,
  output logic              dclk_o,
  output logic              data_o,
  output logic              status_o,
  output logic              busy_o,
  output logic              result_valid_o,
  output logic              pass_o,
  output logic              err_o
);
  localparam int unsigned PULSE_CYC  = ns_to_cycles(SYS_CLK_HZ, PULSE_NS);
  localparam int unsigned SETTLE_CYC = ns_to_cycles(SYS_CLK_HZ, SETTLE_NS);
  localparam int unsigned TMR_MAX    = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int unsigned TW         = $clog2(TMR_MAX + 1);
  localparam int unsigned LOW_EFF    = (LOW_CYC  < 1) ? 1 : LOW_CYC;
  localparam int unsigned HIGH_EFF   = (HIGH_CYC < 1) ? 1 : HIGH_CYC;

  seq_state_e    state_q;
  logic          fin_q;
  logic          shift_run, can_load, word_end, accept;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_len;

  assign shift_run = (state_q == ST_STREAM) && status_o;
  assign ready_o   = shift_run && can_load && !fin_q;
  assign accept    = valid_i && ready_o;
  assign tmr_load  = ((state_q == ST_IDLE) && start_i) || (shift_run && word_end && fin_q);
  assign tmr_len   = (state_q == ST_IDLE) ? TW'(PULSE_CYC) : TW'(SETTLE_CYC);

  psc_timer #(.W(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_exp)
  );

  psc_shifter #(.LOW_CYC(LOW_EFF), .HIGH_CYC(HIGH_EFF)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (shift_run),
    .load_i     (accept),
    .byte_i     (byte_i),
    .can_load_o (can_load),
    .word_end_o (word_end),
    .dclk_o     (dclk_o),
    .data_o     (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      fin_q          <= 1'b0;
      status_o       <= 1'b0;
      cfg_n_o        <= 1'b1;
      busy_o         <= 1'b0;
      result_valid_o <= 1'b0;
      pass_o         <= 1'b0;
      err_o          <= 1'b0;
    end else begin
      status_o       <= status_i;
      result_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PULSE;
          cfg_n_o <= 1'b0;
          busy_o  <= 1'b1;
          err_o   <= 1'b0;
          pass_o  <= 1'b0;
          fin_q   <= 1'b0;
        end
        ST_PULSE: if (tmr_exp) begin
          state_q <= ST_STREAM;
          cfg_n_o <= 1'b1;
        end
        ST_STREAM: begin
          if (!status_o) begin
            state_q <= ST_IDLE;
            err_o   <= 1'b1;
            busy_o  <= 1'b0;
          end else begin
            if (accept) fin_q <= last_i;
            if (word_end && fin_q) state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: if (tmr_exp) begin
          state_q        <= ST_IDLE;
          result_valid_o <= 1'b1;
          pass_o         <= done_i;
          busy_o         <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psc_checker.sv
module psc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic cfg_n_o,
  input logic dclk_o,
  input logic data_o,
  input logic busy_o,
  input logic result_valid_o,
  input logic err_o
);
  // R3
  data_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != $past(data_o)) |-> (!dclk_o && !$past(dclk_o)));
  // R1
  cfg_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_n_o |-> busy_o);
  // R5
  result_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  // R9
  result_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (!busy_o && $past(busy_o)));
  // R8
  idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dclk_o);
  // R8
  idle_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !data_o);
  // R7
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  // R4
  ready_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (busy_o && cfg_n_o));
endmodule

bind ps_cfg_master psc_checker u_psc_chk (.*);

// File: tb/ps_cfg_master_bench.sv
`timescale 1ns/1ps
module ps_cfg_master_bench;
  localparam int LC = 2, HC = 2;
  localparam int SLOT = 1 + LC + HC;
  localparam int P_CYC = 625;   // 5 us at 125 MHz
  localparam int S_CYC = 1250;  // 10 us at 125 MHz

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, valid_i = 0, last_i = 0, status_i = 1, done_i = 0;
  logic [7:0] byte_i = '0;
  logic ready_o, cfg_n_o, dclk_o, data_o, status_o, busy_o, result_valid_o, pass_o, err_o;

  always #4 clk_i = ~clk_i;

  ps_cfg_master u_ps_cfg_master (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  // behavioural reference
  int m_mode, m_t, m_slot;
  bit m_bits[$];
  bit e_cfg, e_dclk, e_data, e_busy, e_rv, e_pass, e_err, e_stat, e_fin;

  function automatic bit e_ready();
    return m_mode == 2 && e_stat && !e_fin &&
           (m_bits.size() == 0 || (m_slot == SLOT - 1 && m_bits.size() == 1));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_t = 0; m_slot = 0; m_bits.delete();
      e_cfg = 1; e_dclk = 0; e_data = 0; e_busy = 0; e_rv = 0;
      e_pass = 0; e_err = 0; e_stat = 0; e_fin = 0;
    end else begin
      bit acc, old_stat;
      acc = valid_i && e_ready();
      old_stat = e_stat;
      e_stat = status_i;
      e_rv = 0;
      case (m_mode)
        0: begin
          if (!e_dclk) e_data = 0;
          if (start_i) begin
            m_mode = 1; m_t = 0; e_cfg = 0; e_busy = 1;
            e_err = 0; e_pass = 0; e_fin = 0;
          end
        end
        1: begin
          m_t++;
          if (m_t == P_CYC) begin m_mode = 2; e_cfg = 1; end
        end
        2: begin
          if (!old_stat) begin
            m_mode = 0; e_err = 1; e_busy = 0;
            if (!e_dclk) e_data = 0;
            e_dclk = 0; m_bits.delete();
          end else if (m_bits.size() == 0) begin
            if (acc) begin
              for (int i = 0; i < 8; i++) m_bits.push_back(byte_i[i]);
              m_slot = 0; e_fin = last_i;
            end
          end else if (m_slot == SLOT - 1) begin
            void'(m_bits.pop_front());
            e_dclk = 0; m_slot = 0;
            if (m_bits.size() == 0) begin
              if (acc) begin
                for (int i = 0; i < 8; i++) m_bits.push_back(byte_i[i]);
                e_fin = last_i;
              end else if (e_fin) begin
                m_mode = 3; m_t = 0;
              end
            end
          end else begin
            m_slot++;
            if (m_slot == 1) e_data = m_bits[0];
            if (m_slot == 1 + LC) e_dclk = 1;
          end
        end
        default: begin
          if (!e_dclk) e_data = 0;
          m_t++;
          if (m_t == S_CYC) begin
            e_rv = 1; e_pass = done_i; e_busy = 0; m_mode = 0;
          end
        end
      endcase
    end
  end

  // per-clock comparison plus rising-edge capture of serial data
  bit cap_q[$];
  bit cap_prev = 0;
  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      chk("R1 cfg_n_o", cfg_n_o, e_cfg);
      chk("R3 dclk_o", dclk_o, e_dclk);
      chk("R2 data_o", data_o, e_data);
      chk("R4 ready_o", ready_o, e_ready());
      chk("R5 result_valid_o", result_valid_o, e_rv);
      chk("R5 pass_o", pass_o, e_pass);
      chk("R6 status_o", status_o, e_stat);
      chk("R7 err_o", err_o, e_err);
      chk("R9 busy_o", busy_o, e_busy);
      if (dclk_o && !cap_prev) cap_q.push_back(data_o);
      cap_prev = dclk_o;
    end
  end

  logic [7:0] tx_q[$];

  task automatic run_session(input int gap, input bit done_val, input bit poke, input int abort_at);
    bit hs;
    cap_q.delete();
    done_i = done_val;
    @(negedge clk_i) start_i = 1;
    @(negedge clk_i) start_i = 0;
    chk("R11 err_o cleared", err_o, 1'b0);
    chk("R11 pass_o cleared", pass_o, 1'b0);
    chk("R1 cfg_n_o low", cfg_n_o, 1'b0);
    if (abort_at > 0) fork
      begin repeat (abort_at) @(negedge clk_i); status_i = 0; end
    join_none
    for (int i = 0; i < tx_q.size(); i++) begin
      if (gap > 0 && i > 0) repeat (gap) @(negedge clk_i);
      valid_i = 1; byte_i = tx_q[i]; last_i = (i == tx_q.size() - 1);
      if (poke && i == 2) start_i = 1;
      forever begin
        #1 hs = ready_o;
        @(negedge clk_i);
        if (start_i) begin
          start_i = 0;
          chk("R10 start ignored cfg_n_o", cfg_n_o, 1'b1);
          chk("R10 start ignored busy_o", busy_o, 1'b1);
        end
        if (hs || !busy_o) break;
      end
      valid_i = 0; last_i = 0;
      if (!busy_o) break;
    end
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    status_i = 1;
    chk("R8 idle cfg_n_o", cfg_n_o, 1'b1);
    chk("R8 idle dclk_o", dclk_o, 1'b0);
    chk("R8 idle data_o", data_o, 1'b0);
  endtask

  task automatic check_capture();
    chk("R2 bit count", cap_q.size() == tx_q.size() * 8, 1'b1);
    for (int k = 0; k < tx_q.size(); k++) begin
      logic [7:0] got;
      for (int b = 0; b < 8; b++) got[b] = (k * 8 + b < cap_q.size()) ? cap_q[k * 8 + b] : 1'bx;
      n_cmp++;
      if (got !== tx_q[k]) begin
        n_bad++;
        $display("FAIL R2 byte %0d: got %h expected %h", k, got, tx_q[k]);
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk("R8 reset cfg_n_o", cfg_n_o, 1'b1);
    chk("R8 reset dclk_o", dclk_o, 1'b0);
    chk("R9 reset busy_o", busy_o, 1'b0);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);

    // back-to-back stream, pass, start poked mid-stream
    tx_q = '{8'hA5, 8'h01, 8'h80, 8'hFF};
    run_session(0, 1'b1, 1'b1, 0);
    chk("R5 pass after done high", pass_o, 1'b1);
    check_capture();

    // gapped stream, fail
    tx_q = '{8'h3C, 8'hC3};
    run_session(7, 1'b0, 1'b0, 0);
    chk("R5 fail after done low", pass_o, 1'b0);
    chk("R7 no error", err_o, 1'b0);
    check_capture();

    // status drop mid-stream
    tx_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    run_session(0, 1'b1, 1'b0, P_CYC + 97);
    chk("R7 abort sets err_o", err_o, 1'b1);
    chk("R7 abort gives no pass", pass_o, 1'b0);

    // single byte session after abort
    tx_q = '{8'h5A};
    run_session(0, 1'b1, 1'b0, 0);
    chk("R11 err_o stays clear", err_o, 1'b0);
    chk("R5 single byte pass", pass_o, 1'b1);
    check_capture();

    summary();
  end
endmodule